// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits between a host port that issues one 32-bit write per cycle and a register file whose control registers are 128 bits wide, together with a window of 64-bit memory words. Wide targets cannot be updated a dword at a time. The block therefore gathers the dword writes aimed at one wide target in a single collector. It sends the target a full-width commit only after every part of that target has arrived.

Two page-mapped descriptor-pointer registers take a shortcut so that the host needs no locking for them. A write to their top dword always commits. Any low lanes that the collector does not hold for that same register go out as zero. A write that would mix a second register into a busy collector is dropped. A write to the timer-command register empties the collector. Every other dword passes straight through as a narrow commit. All commits are registered and appear one cycle after the write that causes them.

Top module: `wide_write_collector`

## Requirements
- R1: While synchronous reset is high, the commit strobe is low in the following cycle, and the collector leaves reset empty.
- R2: The ordinary wide registers lie at byte addresses below 0x400. Lane i of such a register sits at offset 4*i. Its four dwords may be written in any order. The register commits one cycle after the write that supplies its last missing lane. That commit has kind 1, a 16-byte aligned address, and data bits [32i+31:32i] equal to lane i.
- R3: The memory window covers 0x80000 to 0x8FFFF in 64-bit words, with the low half at +0 and the high half at +4. A word commits after both halves have arrived. That commit has kind 2, an 8-byte aligned address, the word in bits [63:0] and zero in bits [127:64].
- R4: A descriptor-pointer register sits at in-page offset 0x830 or 0xA10. A write to its top dword (+0xC) always commits it one cycle later with kind 1. The commit uses the register's aligned address and carries the written dword in bits [127:96].
- R5: A descriptor-pointer commit carries the three collected low lanes only when the collector holds all three for that same register. Otherwise bits [95:0] are zero.
- R6: The collector may hold parts of some register. A write to a part of a different wide register or memory word, other than a descriptor top dword, is then discarded. The collector keeps its tag and lanes unchanged.
- R7: A write to any other address commits at once with kind 0, the dword-aligned address and the data in bits [31:0], with the upper bits zero. It leaves the collector untouched.
- R8: A write to the timer-command register (in-page offset 0x420) passes through as in R7. It also empties the collector.
- R9: Each collector commit is a single-cycle strobe and empties the collector, so that the next commit needs a fresh full set of lanes.
- R10: Paged registers repeat with a stride of 0x2000 below the memory window. Descriptor and timer registers are recognised in every page, and the commit address keeps the page bits.
- R11: With the write enable low, the block issues no commit and leaves the collector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Host dword write strobe |
| wr_addr_i | input | 20 | Host byte address |
| wr_data_i | input | 32 | Host write data |
| cmt_valid_o | output | 1 | One-cycle commit strobe toward the register file |
| cmt_kind_o | output | 2 | Commit width: 0 dword, 1 128-bit register, 2 64-bit memory word |
| cmt_addr_o | output | 20 | Aligned byte address of the commit |
| cmt_data_o | output | 128 | Commit data, unused upper bits zero |

## Verification
Two functions can fall in the same cycle when a pass-through commit also changes the collector, and when a descriptor commit finishes while another register sits half-collected. Both are provoked by first leaving a wide register partly collected. The first case then writes the timer-command register in a non-zero page. The second writes a descriptor top dword. Each case is judged at the ports. The scoreboard expects exactly one commit in each of those cycles. It then expects no commit when the abandoned register's remaining lanes arrive, and a commit only after all four lanes have been supplied again.

// File: rtl/wwc_pkg.sv
package wwc_pkg;
    localparam int DW       = 32;
    localparam int LANES    = 4;
    localparam int WIDE_W   = DW * LANES;
    localparam int LANE_IW  = $clog2(LANES);

    // Class of a host access after address decode.
    typedef enum logic [1:0] {
        AC_PLAIN = 2'd0,
        AC_WIDE  = 2'd1,
        AC_MEM   = 2'd2,
        AC_DESC  = 2'd3
    } acc_e;

    // Width of a commit toward the register file.
    typedef enum logic [1:0] {
        CK_PLAIN = 2'd0,
        CK_WIDE  = 2'd1,
        CK_MEM   = 2'd2
    } cmt_kind_e;

    // Lanes a target needs before it may commit.
    function automatic logic [LANES-1:0] need_mask(input acc_e a);
        return (a == AC_MEM) ? LANES'(4'b0011) : {LANES{1'b1}};
    endfunction
endpackage

// File: rtl/wwc_decode.sv
module wwc_decode
    import wwc_pkg::*;
#(
    parameter int                  ADDR_W     = 20,
    parameter int                  PAGE_SHIFT = 13,
    parameter logic [ADDR_W-1:0]   WIDE_END   = 20'h00400,
    parameter logic [ADDR_W-1:0]   MEM_BASE   = 20'h80000,
    parameter logic [ADDR_W-1:0]   MEM_SIZE   = 20'h10000,
    parameter logic [PAGE_SHIFT-1:0] DESC_A   = 13'h0830,
    parameter logic [PAGE_SHIFT-1:0] DESC_B   = 13'h0A10,
    parameter logic [PAGE_SHIFT-1:0] TMR_OFS  = 13'h0420
) (
    input  logic [ADDR_W-1:0]  addr,
    output acc_e               acc,
    output logic [LANE_IW-1:0] lane,
    output logic [ADDR_W-1:0]  tag,
    output logic               is_timer
);
    localparam logic [ADDR_W:0] MEM_END = {1'b0, MEM_BASE} + {1'b0, MEM_SIZE};

    logic in_mem, below_mem, hit_desc, hit_wide;

    always_comb begin
        in_mem    = (addr >= MEM_BASE) && ({1'b0, addr} < MEM_END);
        below_mem = (addr < MEM_BASE);
        hit_desc  = below_mem &&
                    ((addr[PAGE_SHIFT-1:4] == DESC_A[PAGE_SHIFT-1:4]) ||
                     (addr[PAGE_SHIFT-1:4] == DESC_B[PAGE_SHIFT-1:4]));
        is_timer  = below_mem && (addr[PAGE_SHIFT-1:2] == TMR_OFS[PAGE_SHIFT-1:2]);
        hit_wide  = (addr < WIDE_END);

        acc  = AC_PLAIN;
        lane = '0;
        tag  = {addr[ADDR_W-1:2], 2'b00};
        if (in_mem) begin
            acc  = AC_MEM;
            lane = LANE_IW'(addr[2]);
            tag  = {addr[ADDR_W-1:3], 3'b000};
        end else if (is_timer) begin
            acc  = AC_PLAIN;
        end else if (hit_desc || hit_wide) begin
            acc  = hit_desc ? AC_DESC : AC_WIDE;
            lane = addr[3:2];
            tag  = {addr[ADDR_W-1:4], 4'b0000};
        end
    end
endmodule

// File: rtl/wwc_collector.sv
module wwc_collector
    import wwc_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [DW-1:0]      wr_data,
    input  acc_e               acc,
    input  logic [LANE_IW-1:0] lane,
    input  logic [ADDR_W-1:0]  tag,
    input  logic               is_timer,
    output logic               cmt_valid,
    output cmt_kind_e          cmt_kind,
    output logic [ADDR_W-1:0]  cmt_addr,
    output logic [WIDE_W-1:0]  cmt_data
);
    logic [ADDR_W-1:0]           tag_q, tag_d;
    logic [LANES-1:0]            vmask_q, vmask_d, merged;
    logic [LANES-1:0][DW-1:0]    lane_q, lane_d, lanes_m;
    logic                        hit, drop, full_low, fire;
    cmt_kind_e                   f_kind;
    logic [ADDR_W-1:0]           f_addr;
    logic [WIDE_W-1:0]           f_data;

    always_comb begin
        tag_d    = tag_q;
        vmask_d  = vmask_q;
        lane_d   = lane_q;
        fire     = 1'b0;
        drop     = 1'b0;
        f_kind   = CK_PLAIN;
        f_addr   = tag;
        f_data   = '0;
        hit      = (vmask_q == '0) || (tag_q == tag);
        full_low = (vmask_q != '0) && (tag_q == tag) && (vmask_q[2:0] == 3'b111);
        merged   = vmask_q | (LANES'(1) << lane);
        lanes_m  = lane_q;
        lanes_m[lane] = wr_data;

        if (wr_en) begin
            unique case (acc)
                AC_PLAIN: begin
                    fire   = 1'b1;
                    f_data = {{(WIDE_W-DW){1'b0}}, wr_data};
                    if (is_timer) begin
                        vmask_d = '0;
                        tag_d   = '0;
                    end
                end
                AC_DESC: begin
                    if (lane == LANE_IW'(LANES-1)) begin
                        fire    = 1'b1;
                        f_kind  = CK_WIDE;
                        f_data  = full_low ? {wr_data, lane_q[2], lane_q[1], lane_q[0]}
                                           : {wr_data, {(WIDE_W-DW){1'b0}}};
                        vmask_d = '0;
                        tag_d   = '0;
                    end else if (hit) begin
                        vmask_d = merged;
                        tag_d   = tag;
                        lane_d  = lanes_m;
                    end else begin
                        drop = 1'b1;
                    end
                end
                AC_WIDE, AC_MEM: begin
                    if (hit) begin
                        vmask_d = merged;
                        tag_d   = tag;
                        lane_d  = lanes_m;
                        if ((merged & need_mask(acc)) == need_mask(acc)) begin
                            fire    = 1'b1;
                            vmask_d = '0;
                            tag_d   = '0;
                            if (acc == AC_MEM) begin
                                f_kind = CK_MEM;
                                f_data = {{(WIDE_W-2*DW){1'b0}}, lanes_m[1], lanes_m[0]};
                            end else begin
                                f_kind = CK_WIDE;
                                f_data = lanes_m;
                            end
                        end
                    end else begin
                        drop = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q     <= '0;
            vmask_q   <= '0;
            lane_q    <= '0;
            cmt_valid <= 1'b0;
            cmt_kind  <= CK_PLAIN;
            cmt_addr  <= '0;
            cmt_data  <= '0;
        end else begin
            tag_q     <= tag_d;
            vmask_q   <= vmask_d;
            lane_q    <= lane_d;
            cmt_valid <= fire;
            cmt_kind  <= f_kind;
            cmt_addr  <= f_addr;
            cmt_data  <= f_data;
        end
    end

    // R1: reset silences the commit strobe
    p_rst_quiet_r1: assert property (@(posedge clk) rst |=> !cmt_valid);
    // R11: every commit traces back to a host write
    p_commit_needs_write_r11: assert property (@(posedge clk) disable iff (rst)
        cmt_valid |-> $past(wr_en));
    // R9: a collector commit leaves the collector empty
    p_empty_after_commit_r9: assert property (@(posedge clk) disable iff (rst)
        (cmt_valid && cmt_kind != CK_PLAIN) |-> (vmask_q == '0));
    // R6: a discarded write leaves the collector as it was
    p_drop_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        drop |=> ($stable(vmask_q) && $stable(tag_q) && $stable(lane_q)));
    // R8: timer-command write empties the collector
    p_timer_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && acc == AC_PLAIN && is_timer) |=> (vmask_q == '0));
    // R3: memory word commits keep the upper half zero
    p_mem_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (cmt_valid && cmt_kind == CK_MEM) |-> (cmt_data[WIDE_W-1:2*DW] == '0));
endmodule

// File: rtl/wide_write_collector.sv
module wide_write_collector
    import wwc_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DW-1:0]     wr_data_i,
    output logic              cmt_valid_o,
    output logic [1:0]        cmt_kind_o,
    output logic [ADDR_W-1:0] cmt_addr_o,
    output logic [WIDE_W-1:0] cmt_data_o
);
    acc_e               d_acc;
    logic [LANE_IW-1:0] d_lane;
    logic [ADDR_W-1:0]  d_tag;
    logic               d_timer;
    cmt_kind_e          kind;

    wwc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr     (wr_addr_i),
        .acc      (d_acc),
        .lane     (d_lane),
        .tag      (d_tag),
        .is_timer (d_timer)
    );

    wwc_collector #(.ADDR_W(ADDR_W)) u_collect (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en_i),
        .wr_data   (wr_data_i),
        .acc       (d_acc),
        .lane      (d_lane),
        .tag       (d_tag),
        .is_timer  (d_timer),
        .cmt_valid (cmt_valid_o),
        .cmt_kind  (kind),
        .cmt_addr  (cmt_addr_o),
        .cmt_data  (cmt_data_o)
    );

    assign cmt_kind_o = kind;
endmodule

// File: tb/test_wide_write_collector.sv
module test_wide_write_collector;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [19:0]  wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic         cmt_valid;
    logic [1:0]   cmt_kind;
    logic [19:0]  cmt_addr;
    logic [127:0] cmt_data;

    typedef struct {
        string        req;
        logic [1:0]   kind;
        logic [19:0]  addr;
        logic [127:0] data;
    } exp_t;

    exp_t exp_q[$];
    int   compared = 0;
    int   mismatched = 0;
    bit   done = 0;

    always #5 clk = ~clk;

    wide_write_collector i_wide_write_collector (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .cmt_valid_o(cmt_valid), .cmt_kind_o(cmt_kind), .cmt_addr_o(cmt_addr), .cmt_data_o(cmt_data)
    );

    task automatic expect_c(input string req, input logic [1:0] k,
                            input logic [19:0] a, input logic [127:0] d);
        exp_t e;
        e.req = req; e.kind = k; e.addr = a; e.data = d;
        exp_q.push_back(e);
    endtask

    task automatic wr(input logic [19:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wide4(input logic [19:0] b, input logic [31:0] d0, input logic [31:0] d1,
                         input logic [31:0] d2, input logic [31:0] d3);
        wr(b, d0); wr(b + 20'h4, d1); wr(b + 20'h8, d2); wr(b + 20'hC, d3);
    endtask

    // Monitor: pops the scoreboard on each commit
    always @(negedge clk) begin
        if (!rst && cmt_valid && !done) begin
            compared++;
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL unexpected commit: actual kind=%0d addr=%h data=%h expected none",
                         cmt_kind, cmt_addr, cmt_data);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (cmt_kind !== e.kind || cmt_addr !== e.addr || cmt_data !== e.data) begin
                    mismatched++;
                    $display("FAIL %s: actual kind=%0d addr=%h data=%h expected kind=%0d addr=%h data=%h",
                             e.req, cmt_kind, cmt_addr, cmt_data, e.kind, e.addr, e.data);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: no commit while in reset
        compared++;
        if (cmt_valid !== 1'b0) begin
            mismatched++;
            $display("FAIL R1: actual cmt_valid=%b expected 0", cmt_valid);
        end
        @(negedge clk); rst = 1'b0;

        // R1: collector empty after reset -> lanes 0..2 plus 3 needed
        expect_c("R1", 2'd1, 20'h040, {32'h1003, 32'h1002, 32'h1001, 32'h1000});
        wide4(20'h040, 32'h1000, 32'h1001, 32'h1002, 32'h1003);

        // R2: out-of-order lanes
        wr(20'h108, 32'hA2); wr(20'h100, 32'hA0); wr(20'h10C, 32'hA3);
        expect_c("R2", 2'd1, 20'h100, {32'hA3, 32'hA2, 32'hA1, 32'hA0});
        wr(20'h104, 32'hA1);
        // R2: top of wide range
        expect_c("R2", 2'd1, 20'h3F0, {32'hB3, 32'hB2, 32'hB1, 32'hB0});
        wide4(20'h3F0, 32'hB0, 32'hB1, 32'hB2, 32'hB3);

        // R3: memory word, high half first
        wr(20'h8000C, 32'hC1);
        expect_c("R3", 2'd2, 20'h80008, {64'h0, 32'hC1, 32'hC0});
        wr(20'h80008, 32'hC0);

        // R4: descriptor top only, page 0
        expect_c("R4", 2'd1, 20'h00830, {32'hD3, 96'h0});
        wr(20'h0083C, 32'hD3);

        // R5 R10: full descriptor in page 3
        wr(20'h06A10, 32'hE0); wr(20'h06A14, 32'hE1); wr(20'h06A18, 32'hE2);
        expect_c("R5", 2'd1, 20'h06A10, {32'hE3, 32'hE2, 32'hE1, 32'hE0});
        wr(20'h06A1C, 32'hE3);

        // R5 R10: partial descriptor in page 1 -> zero fill
        wr(20'h02830, 32'hF0); wr(20'h02834, 32'hF1);
        expect_c("R5", 2'd1, 20'h02830, {32'hF3, 96'h0});
        wr(20'h0283C, 32'hF3);

        // R6: writes to other targets while busy are dropped
        wr(20'h200, 32'h20);
        wr(20'h214, 32'h99);
        wr(20'h80000, 32'h98);
        wr(20'h208, 32'h22); wr(20'h20C, 32'h23);
        expect_c("R6", 2'd1, 20'h200, {32'h23, 32'h22, 32'h21, 32'h20});
        wr(20'h204, 32'h21);
        expect_c("R6", 2'd1, 20'h210, {32'h33, 32'h32, 32'h31, 32'h30});
        wide4(20'h210, 32'h30, 32'h31, 32'h32, 32'h33);

        // R7: pass-through in the middle of a collection
        wr(20'h300, 32'h50);
        expect_c("R7", 2'd0, 20'h01234, {96'h0, 32'hCAFE});
        wr(20'h01236, 32'hCAFE);
        wr(20'h304, 32'h51); wr(20'h308, 32'h52);
        expect_c("R7", 2'd0, 20'h300, 128'h0); // placeholder overwritten below
        void'(exp_q.pop_back());
        expect_c("R7", 2'd1, 20'h300, {32'h53, 32'h52, 32'h51, 32'h50});
        wr(20'h30C, 32'h53);

        // R8: timer command (page 2) clears a partial wide collection
        wr(20'h300, 32'h60); wr(20'h304, 32'h61);
        expect_c("R8", 2'd0, 20'h04420, {96'h0, 32'h7777});
        wr(20'h04420, 32'h7777);
        wr(20'h308, 32'h62); wr(20'h30C, 32'h63);
        expect_c("R8", 2'd1, 20'h300, {32'h63, 32'h62, 32'h65, 32'h64});
        wr(20'h300, 32'h64); wr(20'h304, 32'h65);
        // R8: timer command clears a descriptor's low lanes
        wr(20'h00A10, 32'h70); wr(20'h00A14, 32'h71); wr(20'h00A18, 32'h72);
        expect_c("R8", 2'd0, 20'h00420, {96'h0, 32'h1});
        wr(20'h00420, 32'h1);
        expect_c("R8", 2'd1, 20'h00A10, {32'h73, 96'h0});
        wr(20'h00A1C, 32'h73);

        // R9: collector empty after a commit
        wr(20'h10C, 32'h83);
        wr(20'h100, 32'h80); wr(20'h104, 32'h81);
        expect_c("R9", 2'd1, 20'h100, {32'h83, 32'h82, 32'h81, 32'h80});
        wr(20'h108, 32'h82);

        // R4 R9: descriptor top while another register is half collected
        wr(20'h100, 32'h90); wr(20'h104, 32'h91);
        expect_c("R4", 2'd1, 20'h00830, {32'h9D, 96'h0});
        wr(20'h0083C, 32'h9D);
        wr(20'h108, 32'h92); wr(20'h10C, 32'h93);
        expect_c("R9", 2'd1, 20'h100, {32'h93, 32'h92, 32'h95, 32'h94});
        wr(20'h100, 32'h94); wr(20'h104, 32'h95);

        // R11: idle bus with toggling address/data changes nothing
        wr(20'h120, 32'hA0); wr(20'h124, 32'hA1); wr(20'h128, 32'hA2);
        for (int i = 0; i < 5; i++) begin
            wr_addr = 20'h12C; wr_data = 32'hDEAD0000 + 32'(i);
            @(negedge clk);
            compared++;
            if (cmt_valid !== 1'b0) begin
                mismatched++;
                $display("FAIL R11: actual cmt_valid=%b expected 0", cmt_valid);
            end
        end
        expect_c("R11", 2'd1, 20'h120, {32'hA3, 32'hA2, 32'hA1, 32'hA0});
        wr(20'h12C, 32'hA3);

        repeat (4) @(negedge clk);
        compared++;
        if (exp_q.size() != 0) begin
            mismatched++;
            $display("FAIL R9: actual %0d commits missing expected 0", exp_q.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule